// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Loop Divider

This block divides a fast clock by a programmable ratio so that a phase detector can compare the result with a reference. A prescaler runs at one of two sizes. The small size has a base modulus P of 32 and the large size has a base of 64. While a swallow count is still nonzero, the prescaler divides by P+1, and after that it divides by P. A 12-bit main count sets how many prescaler periods make up one full division cycle. The total ratio from the input clock to the output pulse is N×P+A. The output stays low and goes high for exactly one input clock at the end of each division cycle.

The ratio is programmed through plain control pins. A one-clock `load` strobe captures the main count, the swallow count and the prescaler size into a holding register. The counters take those values only when a new division cycle begins, so the cycle in progress is never disturbed. The block has no data stream, so there is no valid/ready handshake and no back-pressure. It takes the strobe on any clock, and the strobe has no acknowledge.

Top module: `swallow_divider`

## Requirements
- R1: With `psel` = 0 (small size, P = 32), rising edges of `pulse_out` are N×32+A input clocks apart.
- R2: With `psel` = 1 (large size, P = 64), rising edges of `pulse_out` are N×64+A input clocks apart.
- R3: `pulse_out` is high for exactly one clock per division cycle and low at all other times.
- R4: Values captured by `load` take effect at the start of the next division cycle, and the cycle already running keeps its old ratio.
- R5: Changes on `n_val`, `a_val` or `psel` while `load` is low have no effect on the ratio.
- R6: A swallow value greater than the effective main value is treated as equal to it.
- R7: In the small size, only the low 5 bits of `a_val` are used, and bit 5 is ignored.
- R8: A main value of 0 is treated as 1.
- R9: While `rst_n` is low, `pulse_out` is low. Reset selects N = 2, A = 0 and the small size, so the first pulse comes 64 clocks after release, counting from the first rising edge after release as clock 1.
- R10: The boundary cases A = 0 (ratio N×P) and A = N (ratio N×(P+1)) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset, held for at least two clocks |
| load | input | 1 | One-clock strobe that captures `n_val`, `a_val` and `psel` |
| psel | input | 1 | Prescaler size: 0 selects P = 32, 1 selects P = 64 |
| n_val | input | 12 | Main count N |
| a_val | input | 6 | Swallow count A |
| pulse_out | output | 1 | Divided output, one clock high per division cycle |

## Verification
`pulse_out` is registered. It rises on the same edge that ends a division cycle, which is edge N×P+A of that cycle. The bench therefore counts falling edges between pulses and expects exactly the ratio, or 64 for the first pulse after reset. A load captured inside cycle k affects cycle k+2, counting the cycle it ends as k. The driver always loads one clock after a pulse and queues the expected periods two cycles ahead, so each comparison lines up with the cycle that actually uses the new values.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic {
    PS_SMALL = 1'b0,
    PS_LARGE = 1'b1
  } psel_e;

  // Length in input clocks of one prescaler period.
  function automatic int unsigned period_len(psel_e size, logic extra,
                                             int unsigned p_small,
                                             int unsigned p_large);
    int unsigned base;
    base = (size == PS_LARGE) ? p_large : p_small;
    return base + (extra ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/swd_cfg_shadow.sv
module swd_cfg_shadow
  import swd_pkg::*;
#(
  parameter int N_W       = 12,
  parameter int A_W       = 6,
  parameter int A_SMALL_W = 5,
  parameter int DEF_N     = 2,
  parameter int DEF_A     = 0,
  parameter bit DEF_SEL   = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  input  logic           sel_in,
  output logic [N_W-1:0] n_eff,
  output logic [A_W-1:0] a_eff,
  output psel_e          sel_eff
);
  localparam int CW = (N_W > A_W) ? N_W : A_W;
  localparam logic [A_W-1:0] SMALL_MASK = A_W'((1 << A_SMALL_W) - 1);

  logic [N_W-1:0] n_q;
  logic [A_W-1:0] a_q;
  psel_e          sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q   <= N_W'(DEF_N);
      a_q   <= A_W'(DEF_A);
      sel_q <= psel_e'(DEF_SEL);
    end else if (load) begin
      n_q   <= n_in;
      a_q   <= a_in;
      sel_q <= psel_e'(sel_in);
    end
  end

  logic [A_W-1:0] a_masked;
  logic [CW-1:0]  a_ext, n_ext;

  always_comb begin
    n_eff    = (n_q == '0) ? N_W'(1) : n_q;
    a_masked = (sel_q == PS_LARGE) ? a_q : (a_q & SMALL_MASK);
    a_ext    = CW'(a_masked);
    n_ext    = CW'(n_eff);
    a_eff    = (a_ext > n_ext) ? A_W'(n_ext) : a_masked;
    sel_eff  = sel_q;
  end

  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(n_q) && $stable(a_q) && $stable(sel_q))); // R5

endmodule

// File: rtl/swd_count_chain.sv
module swd_count_chain
  import swd_pkg::*;
#(
  parameter int N_W = 12,
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tc,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  psel_e          cfg_sel,
  output logic           cyc_end,
  output logic           nxt_long,
  output psel_e          nxt_sel
);
  localparam int CW = (N_W > A_W) ? N_W : A_W;

  logic [N_W-1:0] n_left;
  logic [A_W-1:0] a_left;
  psel_e          sel_act;

  logic           last_period;
  logic           restart;
  logic [A_W-1:0] a_dec;
  logic [A_W-1:0] a_nxt;

  always_comb begin
    last_period = (n_left == N_W'(1));
    cyc_end     = rst_n && pre_tc && last_period;
    restart     = !rst_n || cyc_end;
    a_dec       = (a_left != '0) ? a_left - A_W'(1) : '0;
    a_nxt       = restart ? cfg_a : a_dec;
    nxt_sel     = restart ? cfg_sel : sel_act;
    nxt_long    = (a_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      n_left  <= cfg_n;
      a_left  <= cfg_a;
      sel_act <= cfg_sel;
    end else if (pre_tc) begin
      n_left  <= n_left - N_W'(1);
      a_left  <= a_dec;
    end
  end

  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tc |=> $stable(n_left)); // R4
  AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(a_left) <= CW'(n_left)); // R6
  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    n_left != '0); // R8

endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler
  import swd_pkg::*;
#(
  parameter int P_SMALL = 32,
  parameter int P_LARGE = 64,
  parameter int PRE_W   = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nxt_long,
  input  psel_e nxt_sel,
  output logic  pre_tc
);
  logic [PRE_W-1:0] pre_cnt;

  assign pre_tc = (pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || pre_tc)
      pre_cnt <= PRE_W'(period_len(nxt_sel, nxt_long, P_SMALL, P_LARGE) - 1);
    else
      pre_cnt <= pre_cnt - PRE_W'(1);
  end

  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tc |=> (pre_cnt >= PRE_W'(P_SMALL - 1))); // R2

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int N_W     = 12,
  parameter int A_W     = 6,
  parameter int P_SMALL = 32,
  parameter int P_LARGE = 64,
  parameter int DEF_N   = 2,
  parameter int DEF_A   = 0,
  parameter bit DEF_SEL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           psel,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  output logic           pulse_out
);
  localparam int A_SMALL_W = $clog2(P_SMALL);
  localparam int PRE_W     = $clog2(P_LARGE + 2);

  logic [N_W-1:0] cfg_n;
  logic [A_W-1:0] cfg_a;
  psel_e          cfg_sel;
  logic           pre_tc;
  logic           cyc_end;
  logic           nxt_long;
  psel_e          nxt_sel;

  swd_cfg_shadow #(
    .N_W(N_W), .A_W(A_W), .A_SMALL_W(A_SMALL_W),
    .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .n_in(n_val), .a_in(a_val), .sel_in(psel),
    .n_eff(cfg_n), .a_eff(cfg_a), .sel_eff(cfg_sel)
  );

  swd_count_chain #(.N_W(N_W), .A_W(A_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc),
    .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_sel(cfg_sel),
    .cyc_end(cyc_end), .nxt_long(nxt_long), .nxt_sel(nxt_sel)
  );

  swd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .nxt_long(nxt_long), .nxt_sel(nxt_sel),
    .pre_tc(pre_tc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_out <= 1'b0;
    else        pulse_out <= cyc_end;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |=> !pulse_out); // R3

endmodule

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;
  localparam int N_W = 12;
  localparam int A_W = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           load = 1'b0;
  logic           psel = 1'b0;
  logic [N_W-1:0] n_val = '0;
  logic [A_W-1:0] a_val = '0;
  logic           pulse_out;

  always #2 clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk(clk), .rst_n(rst_n), .load(load), .psel(psel),
    .n_val(n_val), .a_val(a_val), .pulse_out(pulse_out)
  );

  typedef struct {
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    finished = 1'b0;

  task automatic push(input int e, input string r);
    item_t it;
    it.exp = e;
    it.req = r;
    q.push_back(it);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (pulse_out !== 1'b1);
  endtask

  // Load a new ratio one clock into a cycle; it applies two cycles ahead.
  task automatic step(input int n, input int a, input bit s,
                      input int e, input string r);
    wait_pulse();
    n_val = N_W'(n);
    a_val = A_W'(a);
    psel  = s;
    load  = 1'b1;
    push(e, r);
    @(negedge clk);
    load = 1'b0;
  endtask

  // Keep the ratio but disturb the inputs with load low (R5).
  task automatic keep(input int e, input string r);
    wait_pulse();
    push(e, r);
    n_val = ~n_val;
    a_val = ~a_val;
    psel  = ~psel;
  endtask

  // Monitor: period between pulses against the scoreboard.
  initial begin
    int  cnt;
    bit  prev;
    item_t it;
    cnt  = 0;
    prev = 1'b0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (done) break;
      cnt++;
      if (prev && pulse_out) begin
        checks++; errors++;
        $display("FAIL R3 pulse wider than one clock: actual 2+ expected 1");
      end
      if (pulse_out === 1'b1) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R4 unexpected pulse: actual period %0d expected none", cnt);
        end else begin
          it = q.pop_front();
          if (cnt != it.exp) begin
            errors++;
            $display("FAIL %s period: actual %0d expected %0d", it.req, cnt, it.exp);
          end
        end
        cnt = 0;
      end
      prev = pulse_out;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (pulse_out !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset output: actual %b expected 0", pulse_out);
    end
    push(64, "R9");
    push(64, "R9");
    rst_n = 1'b1;

    step(5, 3, 1'b0, 163, "R1");       // 5*32+3
    keep(163, "R5");
    step(4, 2, 1'b1, 258, "R2");       // 4*64+2, cycle between keeps R1 ratio (R4)
    keep(258, "R5");
    step(3, 3, 1'b0, 99, "R10");       // A = N: 3*33
    step(7, 0, 1'b1, 448, "R10");      // A = 0: 7*64
    step(2, 7, 1'b1, 130, "R6");       // A clamped to 2: 2*64+2
    step(4, 33, 1'b0, 129, "R7");      // bit 5 dropped, A = 1: 4*32+1
    step(0, 0, 1'b0, 32, "R8");        // N = 0 -> 1
    step(0, 5, 1'b1, 65, "R8");        // N -> 1, A clamped to 1
    step(100, 31, 1'b0, 3231, "R1");   // 100*32+31
    keep(3231, "R4");

    while (q.size() != 0) @(negedge clk);
    done = 1'b1;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual no finish expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule